// File: doc/BRIEF.md
# Sense-Reversing Barrier Controller

This block lets a fixed group of participants meet at a common point before any of them goes on. Each participant signals its arrival with a one-cycle pulse and then waits for its release line to come back high. When every participant has arrived, all release lines rise together and the barrier is at once ready for the next round.

Inside, each participant keeps one sense bit and the barrier keeps one shared flag and an arrival counter. An arrival flips the participant's sense bit, which pulls its release line low, because release is high exactly when the sense bit matches the flag. When the arrivals of a round reach the participant count, the counter wraps to zero and the flag takes the new sense, so every waiter matches again. The flag is never cleared between rounds. It only changes polarity, so a participant that re-enters straight away waits on the opposite value and cannot be let through by the flag of the round that just ended. Arrivals in the same cycle are summed with an adder, so none is lost.

Top module: `sense_barrier`

## Requirements
- R1: After reset the counter, the flag and every sense bit are 0, so every bit of `release_o` is 1.
- R2: An `arrive_i` pulse from a participant whose `release_o` is high, and that does not complete the round, drives that participant's `release_o` low in the next cycle.
- R3: An `arrive_i` pulse from a participant whose `release_o` is low is ignored. It is not counted and does not change any `release_o`.
- R4: Any number of arrivals in one cycle are all counted, so a round can finish over any split of the participants across cycles.
- R5: In the cycle after the arrival that brings the round's count to `NUM_PART`, the counter is back at 0 and every bit of `release_o` is 1.
- R6: A participant's `release_o` stays high on every cycle until that participant arrives again.
- R7: A participant that arrives again in the first cycle after a release is held low until all `NUM_PART` participants have arrived in the new round. The polarity left over from the previous round does not release it.
- R8: With `NUM_PART` equal to 1, every arrival completes the round at once, and `release_o` never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| arrive_i | input | NUM_PART | One-cycle arrival pulse, one bit per participant |
| release_o | output | NUM_PART | High when that participant may proceed |

## Verification
The bench drives four participants through every pair of arrival patterns, followed by a closing all-ones pattern. This covers simultaneous arrivals, second arrivals while blocked, and an all-at-once round. A design that summed only one arrival per cycle would leave participants stuck low. A design that counted a second arrival from a blocked participant would release the group early. Rounds are run back to back, so a design that cleared the flag, or compared against a fixed value, would release a fast re-entrant participant in error. A one-participant instance checks that its release line never drops.

// File: rtl/sb_pkg.sv
package sb_pkg;
    // Counter width that can hold 0..p.
    function automatic int cnt_width(int p);
        return (p < 2) ? 1 : $clog2(p + 1);
    endfunction
endpackage

// File: rtl/sb_popcount.sv
module sb_popcount #(
    parameter int N = 4,
    parameter int W = 3
) (
    input  logic [N-1:0] bits_i,
    output logic [W-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            count_o = count_o + W'(bits_i[i]);
        end
    end
endmodule

// File: rtl/sb_sense_bank.sv
module sb_sense_bank #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] flip_i,
    output logic [N-1:0] sense_o
);
    typedef struct packed {
        logic [N-1:0] sense;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (flip_i[i]) st_d.sense[i] = ~st_q.sense[i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sense_o = st_q.sense;
endmodule

// File: rtl/sb_episode.sv
module sb_episode #(
    parameter int N  = 4,
    parameter int CW = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] add_i,
    output logic [CW-1:0] cnt_o,
    output logic          flag_o
);
    localparam logic [CW:0] FULL = (CW+1)'(N);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } ep_t;

    ep_t         st_d, st_q;
    logic [CW:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + {1'b0, add_i};
        if (sum == FULL) begin
            st_d.cnt  = '0;
            st_d.flag = ~st_q.flag;
        end else begin
            st_d.cnt  = sum[CW-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
    parameter int NUM_PART = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PART-1:0] arrive_i,
    output logic [NUM_PART-1:0] release_o
);
    localparam int CW = sb_pkg::cnt_width(NUM_PART);

    logic [NUM_PART-1:0] eff_w;
    logic [NUM_PART-1:0] sense_w;
    logic [CW-1:0]       add_w;
    logic [CW-1:0]       cnt_w;
    logic                flag_w;

    // Only participants not already waiting may join the round.
    assign eff_w = arrive_i & release_o;

    sb_popcount #(.N(NUM_PART), .W(CW)) u_pop (
        .bits_i  (eff_w),
        .count_o (add_w)
    );

    sb_sense_bank #(.N(NUM_PART)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flip_i  (eff_w),
        .sense_o (sense_w)
    );

    sb_episode #(.N(NUM_PART), .CW(CW)) u_ep (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .add_i  (add_w),
        .cnt_o  (cnt_w),
        .flag_o (flag_w)
    );

    assign release_o = ~(sense_w ^ {NUM_PART{flag_w}});
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NUM_PART = 4,
    parameter int CW       = 3
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [NUM_PART-1:0] arrive_i,
    input logic [NUM_PART-1:0] release_o,
    input logic [CW-1:0]       cnt_q,
    input logic                flag_q
);
    AST_CNT_BELOW_P: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(cnt_q) < NUM_PART); // R5

    AST_FLAG_FLIP_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q != $past(flag_q)) |-> (cnt_q == '0)); // R5

    AST_FLIP_FREES_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q != $past(flag_q)) |-> (&release_o)); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((arrive_i & release_o) == '0) |=> ($stable(cnt_q) && $stable(flag_q))); // R3

    AST_NO_SPONTANEOUS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(release_o) & ~release_o & ~$past(arrive_i)) == '0)); // R6
endmodule

bind sense_barrier sb_checker #(.NUM_PART(NUM_PART), .CW(CW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arrive_i  (arrive_i),
    .release_o (release_o),
    .cnt_q     (cnt_w),
    .flag_q    (flag_w)
);

// File: tb/sense_barrier_tb.sv
`timescale 1ns/1ps
module sense_barrier_tb;
    localparam int P = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [P-1:0] arrive = '0;
    logic [P-1:0] rel;
    logic         arrive1 = 1'b0;
    logic         rel1;

    logic [P-1:0] waiting = '0;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sense_barrier #(.NUM_PART(P)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .arrive_i(arrive), .release_o(rel));

    sense_barrier #(.NUM_PART(1)) u_dut_one (
        .clk_i(clk), .rst_ni(rst_n), .arrive_i(arrive1), .release_o(rel1));

    task automatic check(input string req, input logic [P-1:0] act, input logic [P-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one pattern for one cycle, advance the model, check after the edge.
    task automatic step(input logic [P-1:0] a, input string req);
        logic [P-1:0] eff;
        logic [P-1:0] nw;
        arrive = a;
        eff = a & ~waiting;
        nw  = waiting | eff;
        waiting = (&nw) ? '0 : nw;
        @(negedge clk);
        arrive = '0;
        check(req, rel, ~waiting);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", rel, '1);
        check("R1", {{(P-1){1'b0}}, rel1}, {{(P-1){1'b0}}, 1'b1});

        step(4'b0001, "R2");            // single arrival blocks participant 0
        step(4'b0000, "R6");            // idle: others stay high
        step(4'b0001, "R3");            // second arrival while blocked ignored
        step(4'b0110, "R4");            // two at once
        step(4'b0001, "R3");            // still three counted, no early release
        step(4'b1000, "R5");            // last arrival releases all
        step(4'b0100, "R7");            // immediate re-entry stays blocked
        step(4'b0000, "R7");
        step(4'b1011, "R5");            // remaining three complete
        step(4'b1111, "R4");            // all at once completes instantly
        repeat (3) step(4'b0000, "R6");

        // One-participant instance: every arrival completes at once.
        for (int k = 0; k < 4; k++) begin
            arrive1 = 1'b1;
            @(negedge clk);
            arrive1 = 1'b0;
            check("R8", {{(P-1){1'b0}}, rel1}, {{(P-1){1'b0}}, 1'b1});
        end

        // Sweep all pairs of patterns, then close the round.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(P'(a), "R4");
                step(P'(b), "R3");
                step(4'b1111, "R5");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule